// File: doc/BRIEF.md
# Detect-Only Tag Check-Bit Checker

This block guards a 26-bit cache tag that sits in storage beside 6 check bits. It has two halves, and neither half has a clock. The first half is an encoder. It turns a tag that is about to be written into its check bits. Five of those bits come from a Hamming code, and the sixth is an overall parity bit. The second half is a checker. It takes a tag and its check bits as read back, forms the syndrome, and sorts the outcome into one of three cases: clean, a single flipped bit, or a double flip.

The checker repairs nothing. The tag compare further up the pipeline has already used the raw tag. For that reason the one flag that matters downstream is the tag-fault flag. It goes high only when bits of the tag itself may be wrong. A lone flip in a check bit leaves the stored tag intact, so the block reports it as a single error and does not raise a fault. A raised tag fault turns an apparent hit into a miss.

Top module: `tag_ecc_detect`

## Requirements
- R1: The encoder places tag bit j at the j-th position from 3 upward that is not a power of two: tag bit 0 at 3, bit 1 at 5, bit 2 at 6, bit 3 at 7, bit 4 at 9, and so on up to 31. Check bit i, for i from 0 to 4, is the XOR of every tag bit whose position has bit i set.
- R2: Check bit 5 is an overall parity bit. It makes the XOR of all 32 stored bits, meaning the 26 tag bits and the 6 check bits, equal to zero.
- R3: When the stored word equals what the encoder produces for the tag, single_err_o, double_err_o and tag_fault_o are all low.
- R4: When only check bit 5 is flipped, single_err_o is high and both double_err_o and tag_fault_o are low.
- R5: When exactly one of check bits 0 to 4 is flipped, single_err_o is high and both double_err_o and tag_fault_o are low.
- R6: When exactly one tag bit is flipped, single_err_o and tag_fault_o are high and double_err_o is low.
- R7: When exactly two stored bits are flipped, in any mix of tag and check bits, double_err_o and tag_fault_o are high and single_err_o is low.
- R8: single_err_o and double_err_o are never high together, and the outputs follow the inputs without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_tag_i | input | 26 | Tag to be encoded for a write |
| enc_check_o | output | 6 | Check bits generated for enc_tag_i |
| rd_tag_i | input | 26 | Tag as read from storage |
| rd_check_i | input | 6 | Check bits as read from storage |
| single_err_o | output | 1 | Exactly one stored bit is flipped |
| double_err_o | output | 1 | Two stored bits are flipped |
| tag_fault_o | output | 1 | The read tag bits may be wrong |

## Verification
The checker is fed three kinds of read word: clean words, words with one flipped bit, and words with two flipped bits. Each flip is walked over every one of the six check bits and every one of the 26 tag bits, which separates a check-bit hit (single error, no fault) from a tag-bit hit (single error with fault). Double flips mix tag with tag, tag with check, and check with check, including pairs that involve the overall parity bit. This shows that every double is classed as a fault whatever its syndrome points at. Tags with all zeros, all ones, alternating bits and random bits exercise every row of the encoder equations.

// File: rtl/tagchk_pkg.sv
// Package: shared sizing helpers for the tag check-bit encoder and checker.
// Assumes a shortened Hamming code with check bits at power-of-two positions.
package tagchk_pkg;

    // Smallest count of Hamming bits that covers k data bits.
    function automatic int hamming_bits(input int k);
        int r;
        r = 1;
        while ((1 << r) < (k + r + 1)) r++;
        return r;
    endfunction

    // Code position (1-based) that holds data bit j.
    function automatic int data_pos(input int j);
        int cnt;
        cnt = 0;
        for (int p = 3; p < 65536; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/tagchk_hamming_gen.sv
// Module: forms the Hamming check bits for a tag, one bit per position bit.
// Assumes: TAG_W data bits laid out by tagchk_pkg::data_pos; no clock.
module tagchk_hamming_gen #(
    parameter int TAG_W = 26,
    parameter int HAM_W = tagchk_pkg::hamming_bits(TAG_W)
) (
    input  logic [TAG_W-1:0] tag_i,
    output logic [HAM_W-1:0] ham_o
);

    // Mask of tag bits whose code position has bit i set.
    function automatic logic [TAG_W-1:0] cover_mask(input int i);
        logic [TAG_W-1:0] m;
        m = '0;
        for (int j = 0; j < TAG_W; j++) begin
            if (((tagchk_pkg::data_pos(j) >> i) & 1) == 1) m[j] = 1'b1;
        end
        return m;
    endfunction

    for (genvar gi = 0; gi < HAM_W; gi++) begin : g_row
        localparam logic [TAG_W-1:0] MASK = cover_mask(gi);
        // Parity over the tag bits covered by this row.
        always_comb ham_o[gi] = ^(tag_i & MASK);
    end

endmodule

// File: rtl/tagchk_encoder.sv
// Module: builds the full check word for a tag, made of Hamming bits plus overall parity.
// Assumes: overall parity is the top bit and makes the XOR of the whole word zero.
module tagchk_encoder #(
    parameter int TAG_W = 26,
    parameter int HAM_W = tagchk_pkg::hamming_bits(TAG_W)
) (
    input  logic [TAG_W-1:0] tag_i,
    output logic [HAM_W:0]   check_o
);

    logic [HAM_W-1:0] ham;

    tagchk_hamming_gen #(.TAG_W(TAG_W), .HAM_W(HAM_W)) ham_i (
        .tag_i (tag_i),
        .ham_o (ham)
    );

    // Append the parity bit that evens out the stored word.
    always_comb check_o = {(^tag_i) ^ (^ham), ham};

endmodule

// File: rtl/tagchk_syndrome.sv
// Module: recomputes the Hamming bits of a read tag and forms the syndrome.
// Assumes: the low HAM_W bits point at a position; the top bit is the parity of the whole word.
module tagchk_syndrome #(
    parameter int TAG_W = 26,
    parameter int HAM_W = tagchk_pkg::hamming_bits(TAG_W)
) (
    input  logic [TAG_W-1:0] tag_i,
    input  logic [HAM_W:0]   check_i,
    output logic [HAM_W:0]   syn_o
);

    logic [HAM_W-1:0] ham_re;

    tagchk_hamming_gen #(.TAG_W(TAG_W), .HAM_W(HAM_W)) ham_i (
        .tag_i (tag_i),
        .ham_o (ham_re)
    );

    // Compare the recomputed bits with the stored ones; fold the whole word for parity.
    always_comb syn_o = {(^tag_i) ^ (^check_i), ham_re ^ check_i[HAM_W-1:0]};

endmodule

// File: rtl/tagchk_classify.sv
// Module: sorts a syndrome into clean, single or double, and flags a tag fault.
// Assumes: a position past the last used one can only come from several flips,
// so it is reported as a double; with 26 tag bits this case cannot arise.
module tagchk_classify #(
    parameter int TAG_W = 26,
    parameter int HAM_W = tagchk_pkg::hamming_bits(TAG_W)
) (
    input  logic [HAM_W:0] syn_i,
    output logic           single_o,
    output logic           double_o,
    output logic           fault_o
);

    localparam int              MAX_POS   = TAG_W + HAM_W;
    localparam logic [HAM_W-1:0] MAX_POS_V = HAM_W'(MAX_POS);

    logic [HAM_W-1:0] low;
    logic             odd;
    logic             low_nz;
    logic             low_pow2;
    logic             in_range;

    // Split the syndrome and decode where the low part points.
    always_comb begin
        low      = syn_i[HAM_W-1:0];
        odd      = syn_i[HAM_W];
        low_nz   = |low;
        low_pow2 = low_nz && ((low & (low - 1'b1)) == '0);
        in_range = (low <= MAX_POS_V);
    end

    // Classify; only a tag-position hit or any double marks the tag as suspect.
    always_comb begin
        single_o = odd && in_range;
        double_o = (!odd && low_nz) || (odd && !in_range);
        fault_o  = double_o || (odd && low_nz && !low_pow2 && in_range);
    end

endmodule

// File: rtl/tag_ecc_detect.sv
// Module: top of the detect-only tag checker, holding a write-side encoder and
// a read-side checker. It corrects nothing and has no state.
// Assumes: stored words were written with the same encoder.
module tag_ecc_detect #(
    parameter  int TAG_W = 26,
    localparam int HAM_W = tagchk_pkg::hamming_bits(TAG_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [TAG_W-1:0] enc_tag_i,
    output logic [CHK_W-1:0] enc_check_o,
    input  logic [TAG_W-1:0] rd_tag_i,
    input  logic [CHK_W-1:0] rd_check_i,
    output logic             single_err_o,
    output logic             double_err_o,
    output logic             tag_fault_o
);

    logic [CHK_W-1:0] syn;

    tagchk_encoder #(.TAG_W(TAG_W), .HAM_W(HAM_W)) enc_i (
        .tag_i   (enc_tag_i),
        .check_o (enc_check_o)
    );

    tagchk_syndrome #(.TAG_W(TAG_W), .HAM_W(HAM_W)) syn_i (
        .tag_i   (rd_tag_i),
        .check_i (rd_check_i),
        .syn_o   (syn)
    );

    tagchk_classify #(.TAG_W(TAG_W), .HAM_W(HAM_W)) cls_i (
        .syn_i    (syn),
        .single_o (single_err_o),
        .double_o (double_err_o),
        .fault_o  (tag_fault_o)
    );

endmodule

// File: rtl/tag_ecc_detect_chk.sv
// Module: assertion checker bound to tag_ecc_detect. It uses immediate checks
// on settled combinational values and skips any input that is still unknown.
module tag_ecc_detect_chk #(
    parameter  int TAG_W = 26,
    localparam int HAM_W = tagchk_pkg::hamming_bits(TAG_W),
    localparam int CHK_W = HAM_W + 1
) (
    input logic [TAG_W-1:0] enc_tag_i,
    input logic [CHK_W-1:0] enc_check_o,
    input logic [TAG_W-1:0] rd_tag_i,
    input logic [CHK_W-1:0] rd_check_i,
    input logic             single_err_o,
    input logic             double_err_o,
    input logic             tag_fault_o
);

    logic known;
    logic same_tag;
    logic [CHK_W-1:0] chk_diff;

    // Relate the read word to the encoder output for the same tag.
    always_comb begin
        known    = !$isunknown({enc_tag_i, enc_check_o, rd_tag_i, rd_check_i,
                                single_err_o, double_err_o, tag_fault_o});
        same_tag = (enc_tag_i == rd_tag_i);
        chk_diff = enc_check_o ^ rd_check_i;
    end

    // Flag rules that tie the encoder, syndrome and classifier together.
    always_comb begin
        if (known) begin
            p_clean_quiet_r3: assert (!(same_tag && chk_diff == '0) ||
                                      !(single_err_o || double_err_o || tag_fault_o))
                else $error("clean word raised a flag");
            p_parity_flip_r4: assert (!(same_tag && chk_diff == (CHK_W'(1) << HAM_W)) ||
                                      (single_err_o && !double_err_o && !tag_fault_o))
                else $error("parity-bit flip misclassified");
            p_check_flip_r5: assert (!(same_tag && $countones(chk_diff) == 1) ||
                                     (single_err_o && !tag_fault_o))
                else $error("check-bit flip raised a fault");
            p_fault_flagged_r6: assert (!tag_fault_o || single_err_o || double_err_o)
                else $error("fault without an error class");
            p_double_fault_r7: assert (!double_err_o || tag_fault_o)
                else $error("double without fault");
            p_excl_r8: assert (!(single_err_o && double_err_o))
                else $error("single and double together");
        end
    end

endmodule

bind tag_ecc_detect tag_ecc_detect_chk #(.TAG_W(TAG_W)) chk_i (
    .enc_tag_i    (enc_tag_i),
    .enc_check_o  (enc_check_o),
    .rd_tag_i     (rd_tag_i),
    .rd_check_i   (rd_check_i),
    .single_err_o (single_err_o),
    .double_err_o (double_err_o),
    .tag_fault_o  (tag_fault_o)
);

// File: tb/tag_ecc_detect_tb_top.sv
`timescale 1ns/1ps
module tag_ecc_detect_tb_top;

    localparam int TW = 26;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [TW-1:0] enc_tag = '0;
    logic [CW-1:0] enc_check;
    logic [TW-1:0] rd_tag = '0;
    logic [CW-1:0] rd_check = '0;
    logic          single_err, double_err, tag_fault;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    tag_ecc_detect dut_i (
        .enc_tag_i    (enc_tag),
        .enc_check_o  (enc_check),
        .rd_tag_i     (rd_tag),
        .rd_check_i   (rd_check),
        .single_err_o (single_err),
        .double_err_o (double_err),
        .tag_fault_o  (tag_fault)
    );

    // Scoreboard queues: expected {single,double,fault} and requirement tag
    logic [2:0] exp_q[$];
    string      req_q[$];

    // Reference encoder built from R1/R2: lay out a 32-bit word by position
    function automatic logic [CW-1:0] ref_enc(input logic [TW-1:0] t);
        logic [31:0] word;
        logic [CW-1:0] c;
        int j;
        word = '0;
        j = 0;
        for (int p = 1; p < 32; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                word[p] = t[j];
                j++;
            end
        end
        c = '0;
        for (int i = 0; i < 5; i++)
            for (int p = 1; p < 32; p++)
                if (p[i]) c[i] = c[i] ^ word[p];
        c[5] = (^t) ^ (^c[4:0]);
        return c;
    endfunction

    // Driver: apply a read word and push the expected flags
    task automatic apply(input logic [TW-1:0] t, input logic [CW-1:0] c,
                         input logic [2:0] e, input string req);
        @(posedge clk);
        rd_tag   = t;
        rd_check = c;
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    // Monitor: compare at the falling edge, away from input changes
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            tests++;
            if ({single_err, double_err, tag_fault} !== e) begin
                fails++;
                $display("FAIL %s: tag=%h chk=%h got s/d/f=%b expected %b",
                         r, rd_tag, rd_check, {single_err, double_err, tag_fault}, e);
            end
        end
    end

    task automatic check_enc(input logic [TW-1:0] t);
        @(posedge clk);
        enc_tag = t;
        @(negedge clk);
        tests++;
        if (enc_check !== ref_enc(t)) begin
            fails++;
            $display("FAIL R1/R2: tag=%h got check=%h expected %h", t, enc_check, ref_enc(t));
        end
    endtask

    task automatic sweep(input logic [TW-1:0] t);
        logic [CW-1:0] c;
        c = ref_enc(t);
        check_enc(t);
        apply(t, c, 3'b000, "R3 clean");
        apply(t, c ^ 6'h20, 3'b100, "R4 parity flip");
        for (int k = 0; k < 5; k++)
            apply(t, c ^ (6'h1 << k), 3'b100, "R5 check flip");
        for (int k = 0; k < TW; k++)
            apply(t ^ (26'h1 << k), c, 3'b101, "R6 tag flip");
        for (int k = 0; k < TW - 1; k += 3)
            apply(t ^ (26'h3 << k), c, 3'b011, "R7 tag+tag");
        for (int k = 0; k < CW; k++)
            apply(t ^ (26'h1 << (k * 4)), c ^ (6'h1 << k), 3'b011, "R7 tag+check");
        apply(t, c ^ 6'h03, 3'b011, "R7 check+check");
        apply(t, c ^ 6'h24, 3'b011, "R7 parity+check");
        apply(t, c ^ 6'h30, 3'b011, "R7 parity+check4");
        apply(t ^ 26'h1, c ^ 6'h20, 3'b011, "R7 parity+tag");
        apply(t ^ 26'h2000001, c, 3'b011, "R7 far tag pair");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // Reset state: all-zero word is a valid codeword, so no flags (R3)
        @(negedge clk);
        tests++;
        if ({single_err, double_err, tag_fault} !== 3'b000 || enc_check !== 6'h00) begin
            fails++;
            $display("FAIL R3 reset: flags=%b check=%h expected 000 and 00",
                     {single_err, double_err, tag_fault}, enc_check);
        end
        rst_n = 1'b1;
        sweep(26'h0000000);
        sweep(26'h3FFFFFF);
        sweep(26'h2AAAAAA);
        sweep(26'h1555555);
        sweep(26'h0F0F0F3);
        for (int n = 0; n < 4; n++) sweep(TW'($urandom));
        // R1 single-bit tags pin each tag bit's position
        for (int k = 0; k < TW; k++) check_enc(26'h1 << k);
        // R8: outputs follow inputs between edges with no clock in the path
        @(posedge clk);
        rd_tag = 26'h1234567;
        rd_check = ref_enc(26'h1234567);
        #1;
        rd_tag = rd_tag ^ 26'h10;
        #0.5;
        tests++;
        if ({single_err, double_err, tag_fault} !== 3'b101) begin
            fails++;
            $display("FAIL R8 comb: got %b expected 101", {single_err, double_err, tag_fault});
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule